// File: doc/BRIEF.md
# Decimal Keypad to BCD Priority Encoder

This block turns a row of decimal key lines into a four-bit BCD code. Every digit from one to nine has its own line. When several keys are held at once, the highest digit present wins and the lower ones are dropped. Digit zero has no encoding line, because an idle keypad already encodes as zero. A separate zero-key line exists only so that pressing zero still counts as a key press.

With the default configuration, the key lines and the code output are both active low. The output therefore carries the complement of the BCD value, and an idle keypad drives all ones. A small wrapper adds a key-pressed flag, which is high whenever any of the ten lines is active, including the zero key. The block is purely combinational.

Parameters set the number of digit lines, the polarity of the inputs and of the outputs, and which of two priority-search structures is built.

Top module: `decbcd_prio_enc`

## Requirements
- R1: With every digit line high (inactive), `bcd_n_o` is 4'b1111, the complement of code 0.
- R2: With exactly one digit line low, `bcd_n_o` equals the bitwise complement of that line's digit value.
- R3: With several digit lines low, `bcd_n_o` is the complement of the largest active digit, and every lower active line has no effect on it.
- R4: The level of `zero_key_n_i` never changes `bcd_n_o`. For any fixed pattern on the digit lines, the output is the same with the zero key high and with it low.
- R5: `key_hit_o` is 1 exactly when at least one of the ten lines (`key_n_i` bits or `zero_key_n_i`) is low, and 0 otherwise.
- R6: With only the zero key low, `key_hit_o` is 1 while `bcd_n_o` stays 4'b1111.
- R7: Bit k of `key_n_i` is the line for digit k+1, so bit 0 is digit 1 and bit 8 is digit 9. Bit 0 of `bcd_n_o` is the complement of the code's least significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| key_n_i | input | 9 | Digit key lines, active low; bit k is digit k+1 |
| zero_key_n_i | input | 1 | Zero key line, active low; feeds only the press flag |
| bcd_n_o | output | 4 | Complemented BCD code of the highest active digit |
| key_hit_o | output | 1 | High when any of the ten key lines is active |

## Verification
The code output and the press flag react to the same inputs at the same time. The interesting overlaps are therefore a zero-key press combined with a digit press, and a zero-key press combined with no digit press.

The bench sweeps all 512 digit patterns, each with the zero key both released and held. For every point it compares the code with a downward priority search written in the bench, and compares the flag with a reduction over all ten lines. It also checks that holding the zero key leaves the code identical to its value with the zero key released.

// File: rtl/decbcd_pkg.sv
package decbcd_pkg;

   // Structure used to locate the highest active digit line
   typedef enum logic {
      SCAN_LINEAR = 1'b0,   // upward loop, later hits overwrite earlier ones
      SCAN_ONEHOT = 1'b1    // isolate the top line as one-hot, then OR-encode
   } scan_e;

   // Bits needed to hold the values 0..num_digits
   function automatic int code_width(input int num_digits);
      return $clog2(num_digits + 1);
   endfunction

endpackage

// File: rtl/decbcd_polarity.sv
module decbcd_polarity #(
   parameter int W      = 1,
   parameter bit INVERT = 1'b1
) (
   input  logic [W-1:0] in_i,
   output logic [W-1:0] out_o
);

   if (W < 1) begin : g_bad_width
      $error("decbcd_polarity: W must be at least 1");
   end

   if (INVERT) begin : g_inv
      assign out_o = ~in_i;
   end else begin : g_pass
      assign out_o = in_i;
   end

endmodule

// File: rtl/decbcd_prio_core.sv
module decbcd_prio_core
   import decbcd_pkg::*;
#(
   parameter int    N    = 9,
   parameter int    CW   = 4,
   parameter scan_e IMPL = SCAN_ONEHOT
) (
   input  logic [N-1:0]  act_i,    // active-high; bit k is digit k+1
   output logic [CW-1:0] code_o
);

   if (N < 1) begin : g_bad_n
      $error("decbcd_prio_core: N must be at least 1");
   end
   if (CW < code_width(N)) begin : g_bad_cw
      $error("decbcd_prio_core: CW too narrow for N digits");
   end

   // For code bit b: mask of the lines whose digit value has bit b set
   function automatic logic [N-1:0] bit_mask(input int b);
      logic [N-1:0] m;
      m = '0;
      for (int k = 0; k < N; k++) begin
         m[k] = (((k + 1) >> b) & 1) != 0;
      end
      return m;
   endfunction

   if (IMPL == SCAN_LINEAR) begin : g_linear
      always_comb begin
         code_o = '0;
         for (int k = 0; k < N; k++) begin
            if (act_i[k]) code_o = CW'(k + 1);
         end
      end
   end else begin : g_onehot
      logic [N:0]   above;   // above[k]: some line at index >= k is active
      logic [N-1:0] top_sel; // one-hot: the highest active line

      assign above[N] = 1'b0;
      for (genvar k = 0; k < N; k++) begin : g_chain
         assign above[k]   = above[k+1] | act_i[k];
         assign top_sel[k] = act_i[k] & ~above[k+1];
      end

      for (genvar b = 0; b < CW; b++) begin : g_enc
         localparam logic [N-1:0] MASK = bit_mask(b);
         assign code_o[b] = |(top_sel & MASK);
      end
   end

endmodule

// File: rtl/decbcd_key_detect.sv
module decbcd_key_detect #(
   parameter int N = 9
) (
   input  logic [N-1:0] act_i,
   input  logic         zero_act_i,
   output logic         hit_o
);

   if (N < 1) begin : g_bad_n
      $error("decbcd_key_detect: N must be at least 1");
   end

   assign hit_o = (|act_i) | zero_act_i;

endmodule

// File: rtl/decbcd_prio_enc.sv
module decbcd_prio_enc
   import decbcd_pkg::*;
#(
   parameter int    NUM_DIGITS     = 9,
   parameter bit    IN_ACTIVE_LOW  = 1'b1,
   parameter bit    OUT_ACTIVE_LOW = 1'b1,
   parameter scan_e SCAN_IMPL      = SCAN_ONEHOT,
   localparam int   CODE_W         = code_width(NUM_DIGITS)
) (
   input  logic [NUM_DIGITS-1:0] key_n_i,
   input  logic                  zero_key_n_i,
   output logic [CODE_W-1:0]     bcd_n_o,
   output logic                  key_hit_o
);

   if (NUM_DIGITS < 1 || NUM_DIGITS > 255) begin : g_bad_digits
      $error("decbcd_prio_enc: NUM_DIGITS out of range");
   end

   logic [NUM_DIGITS-1:0] digit_act;
   logic                  zero_act;
   logic [CODE_W-1:0]     code;

   decbcd_polarity #(.W(NUM_DIGITS), .INVERT(IN_ACTIVE_LOW)) u_in_pol (
      .in_i  (key_n_i),
      .out_o (digit_act)
   );

   decbcd_polarity #(.W(1), .INVERT(IN_ACTIVE_LOW)) u_zero_pol (
      .in_i  (zero_key_n_i),
      .out_o (zero_act)
   );

   decbcd_prio_core #(.N(NUM_DIGITS), .CW(CODE_W), .IMPL(SCAN_IMPL)) u_core (
      .act_i  (digit_act),
      .code_o (code)
   );

   decbcd_polarity #(.W(CODE_W), .INVERT(OUT_ACTIVE_LOW)) u_out_pol (
      .in_i  (code),
      .out_o (bcd_n_o)
   );

   decbcd_key_detect #(.N(NUM_DIGITS)) u_detect (
      .act_i      (digit_act),
      .zero_act_i (zero_act),
      .hit_o      (key_hit_o)
   );

endmodule

// File: rtl/decbcd_prio_enc_chk.sv
module decbcd_prio_enc_chk #(
   parameter int N      = 9,
   parameter int CW     = 4,
   parameter bit IN_AL  = 1'b1,
   parameter bit OUT_AL = 1'b1
) (
   input logic [N-1:0]  key_n_i,
   input logic          zero_key_n_i,
   input logic [CW-1:0] bcd_n_o,
   input logic          key_hit_o
);

   logic [N-1:0]  act;
   logic          zact;
   logic [CW-1:0] code;
   logic          sel_active;
   logic          higher_idle;

   always_comb begin
      act         = IN_AL ? ~key_n_i : key_n_i;
      zact        = IN_AL ? ~zero_key_n_i : zero_key_n_i;
      code        = OUT_AL ? ~bcd_n_o : bcd_n_o;
      sel_active  = 1'b0;
      higher_idle = 1'b1;
      for (int k = 0; k < N; k++) begin
         if (int'(code) == k + 1 && act[k]) sel_active = 1'b1;
         if (k + 1 > int'(code) && act[k])  higher_idle = 1'b0;
      end

      // R1: an idle keypad encodes as zero
      if (act == '0) a_r1_idle_zero: assert (code == '0);
      // R2: a nonzero code names a line that is really active
      if (code != '0) a_r2_sel_active: assert (sel_active);
      // R3: no active line lies above the encoded digit
      a_r3_higher_idle: assert (higher_idle);
      // R7: the code never exceeds the highest digit
      a_r7_code_range: assert (int'(code) <= N);
      // R5: the press flag tracks all ten lines
      a_r5_hit_any: assert (key_hit_o == ((|act) | zact));
      // R6: the zero key alone raises the flag with a zero code
      if (act == '0 && zact) a_r6_zero_only: assert (key_hit_o && code == '0);
   end

endmodule

bind decbcd_prio_enc decbcd_prio_enc_chk #(
   .N      (NUM_DIGITS),
   .CW     (CODE_W),
   .IN_AL  (IN_ACTIVE_LOW),
   .OUT_AL (OUT_ACTIVE_LOW)
) u_chk (
   .key_n_i      (key_n_i),
   .zero_key_n_i (zero_key_n_i),
   .bcd_n_o      (bcd_n_o),
   .key_hit_o    (key_hit_o)
);

// File: tb/decbcd_prio_enc_test.sv
module decbcd_prio_enc_test;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 9;
   localparam int CW         = 4;
   localparam int WATCHDOG   = 20000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  key_n = '1;
   logic          zero_n = 1'b1;
   logic [CW-1:0] bcd_n;
   logic          hit;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   decbcd_prio_enc uut (
      .key_n_i      (key_n),
      .zero_key_n_i (zero_n),
      .bcd_n_o      (bcd_n),
      .key_hit_o    (hit)
   );

   task automatic check4(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s keys=%b zero=%b actual=%b expected=%b", req, key_n, zero_n, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s keys=%b zero=%b actual=%b expected=%b", req, key_n, zero_n, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG && !done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [CW-1:0] bcd_released;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R1 reset/idle state
      check4("R1 idle code", bcd_n, 4'b1111);
      check1("R5 idle flag", hit, 1'b0);

      for (int p = 0; p < (1 << N); p++) begin
         int exp_d;
         int active_cnt;
         logic exp_hit;
         exp_d = 0;
         active_cnt = 0;
         for (int d = N; d >= 1; d--) begin
            if (!p[d-1]) begin
               active_cnt++;
               if (exp_d == 0) exp_d = d;
            end
         end
         bcd_released = '0;
         for (int z = 1; z >= 0; z--) begin
            @(negedge clk);
            key_n  = N'(p);
            zero_n = z[0];
            #1;
            if (active_cnt == 0)      check4("R1 no digit", bcd_n, ~CW'(exp_d));
            else if (active_cnt == 1) check4("R2 R7 single", bcd_n, ~CW'(exp_d));
            else                      check4("R3 highest wins", bcd_n, ~CW'(exp_d));
            exp_hit = (active_cnt != 0) || (z == 0);
            if (active_cnt == 0 && z == 0) check1("R6 zero only flag", hit, exp_hit);
            else                           check1("R5 flag", hit, exp_hit);
            if (z == 1) bcd_released = bcd_n;
            else        check4("R4 zero key no effect", bcd_n, bcd_released);
         end
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule